// File: doc/BRIEF.md
# Per-Processor Interrupt Presenter with Reject Path

This block sits between a source controller and one processor. Each cycle it may receive a delivery: a source number and an 8-bit priority. It compares the delivery with the processor's current priority and with whatever interrupt is already pending. It then either takes the delivery or sends it back on a one-cycle reject pulse. A smaller priority number is more favoured.

A taken delivery that pushes out a less favoured pending source triggers a reject for the pushed-out source. The source controller can then deliver that source again later. Pushed-out interrupts are never queued.

Software drives three commands:
- An accept read takes the pending interrupt. The pending word is visible on `pend_word` at all times.
- An end-of-interrupt write restores the processor priority.
- An inter-processor interrupt write loads a priority register. When that register is favoured enough, the block presents a reserved source number.

Top module: `ipc_presenter`

## Requirements
- R1: After reset, `pend_word` is zero (processor priority 0, source field 0), `irq_out` and `rej_valid` are low, and the inter-processor priority holds 0xFF, which never presents an interrupt.
- R2: A delivery whose priority is numerically greater than or equal to the processor priority (`pend_word[31:24]`) is refused. In the next cycle `rej_valid` pulses for one cycle and `rej_src` carries the refused source number.
- R3: While a source is pending (`pend_word[23:0]` non-zero), a delivery whose priority is numerically greater than or equal to the pending priority is refused and rejected as in R2.
- R4: A delivery that is not refused is taken. In the next cycle `pend_word[23:0]` holds its source number, `pend_word[31:24]` is unchanged and `irq_out` is high.
- R5: When a taken delivery replaces a pending source other than the reserved source 2, the replaced source number appears on `rej_src` with `rej_valid` in the next cycle. A replaced source 2 is dropped without a reject.
- R6: An accept read (`ack_rd`) with a source pending makes `pend_word[31:24]` equal to the pending priority, clears `pend_word[23:0]` and lowers `irq_out` in the next cycle. With nothing pending it changes nothing.
- R7: An inter-processor write loads `ipi_prio`. If that value is below the processor priority, and either nothing is pending or the value is below the pending priority, source 2 is presented with that value as its pending priority. A pending source other than 2 that it replaces is rejected as in R5.
- R8: An end-of-interrupt write sets the processor priority to `eoi_prio`. In the same step the stored inter-processor priority is re-evaluated against the new processor priority under the rule of R7.
- R9: At most one software command acts per cycle, in the order accept read, end-of-interrupt, inter-processor write. A delivery with source 0 is ignored. A delivery that arrives together with any software command is refused and rejected, and in that cycle the inter-processor evaluation may present source 2 only if nothing is pending or source 2 is already pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dlv_valid | input | 1 | Delivery present this cycle |
| dlv_src | input | 24 | Delivered source number |
| dlv_prio | input | 8 | Delivered priority |
| ack_rd | input | 1 | Accept read strobe |
| eoi_wr | input | 1 | End-of-interrupt write strobe |
| eoi_prio | input | 8 | Processor priority written at end of interrupt |
| ipi_wr | input | 1 | Inter-processor priority write strobe |
| ipi_prio | input | 8 | Inter-processor priority value |
| pend_word | output | 32 | Processor priority (31:24) and pending source (23:0) |
| irq_out | output | 1 | Interrupt line to the processor |
| rej_valid | output | 1 | Reject notification pulse |
| rej_src | output | 24 | Source number being rejected |

## Verification
A corrupted processor or pending priority shows up at the next delivery whose priority falls near it. That delivery is taken where a reject was due, or the reverse, and `rej_valid` shows the error one cycle after the delivery. A stale source field is visible on `pend_word` at once. It also surfaces as a wrong `rej_src` on the next displacement. A wrong stored inter-processor priority stays hidden until the next end-of-interrupt write, where source 2 appears or fails to appear in the following cycle.

// File: rtl/ipc_pkg.sv
package ipc_pkg;
  parameter int unsigned PRIO_W = 8;
  parameter int unsigned SRC_W  = 24;
  localparam int unsigned WORD_W = PRIO_W + SRC_W;

  typedef logic [PRIO_W-1:0] prio_t;
  typedef logic [SRC_W-1:0]  src_t;

  localparam prio_t PRIO_NONE = '1;

  // a is strictly more favoured than b (smaller number wins)
  function automatic logic favours(prio_t a, prio_t b);
    return a < b;
  endfunction

  // an offer at priority inc beats the processor mask and any pending one
  function automatic logic wins(prio_t inc, prio_t cppr, logic busy, prio_t pend);
    return favours(inc, cppr) && (!busy || favours(inc, pend));
  endfunction
endpackage

// File: rtl/ipc_accept_arb.sv
module ipc_accept_arb
  import ipc_pkg::*;
(
  input  logic  dlv_valid,
  input  src_t  dlv_src,
  input  prio_t dlv_prio,
  input  logic  sw_busy,
  input  prio_t cppr,
  input  logic  busy,
  input  prio_t pend_prio,
  output logic  take,
  output logic  refuse
);
  logic live;

  always_comb begin
    live   = dlv_valid && (dlv_src != '0);
    take   = live && !sw_busy && wins(dlv_prio, cppr, busy, pend_prio);
    refuse = live && !take;
  end
endmodule

// File: rtl/ipc_ipi_eval.sv
module ipc_ipi_eval
  import ipc_pkg::*;
#(
  parameter int unsigned IPI_SRC = 2
) (
  input  logic  en,
  input  prio_t mfrr,
  input  prio_t cppr,
  input  logic  busy,
  input  src_t  pend_src,
  input  prio_t pend_prio,
  input  logic  allow_displace,
  output logic  present,
  output logic  displace
);
  localparam src_t IpiSrc = src_t'(IPI_SRC);
  logic pend_is_ipi;

  always_comb begin
    pend_is_ipi = (pend_src == IpiSrc);
    present  = en && wins(mfrr, cppr, busy, pend_prio)
               && (!busy || pend_is_ipi || allow_displace);
    displace = present && busy && !pend_is_ipi;
  end
endmodule

// File: rtl/ipc_presenter.sv
module ipc_presenter
  import ipc_pkg::*;
#(
  parameter int unsigned IPI_SRC = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                dlv_valid,
  input  logic [SRC_W-1:0]    dlv_src,
  input  logic [PRIO_W-1:0]   dlv_prio,
  input  logic                ack_rd,
  input  logic                eoi_wr,
  input  logic [PRIO_W-1:0]   eoi_prio,
  input  logic                ipi_wr,
  input  logic [PRIO_W-1:0]   ipi_prio,
  output logic [WORD_W-1:0]   pend_word,
  output logic                irq_out,
  output logic                rej_valid,
  output logic [SRC_W-1:0]    rej_src
);
  localparam src_t IpiSrc = src_t'(IPI_SRC);

  prio_t cppr_q, pprio_q, mfrr_q;
  src_t  xsrc_q;

  // named internal events (observed by the checker)
  logic  busy_w, sw_busy_w, op_ack_w, op_eoi_w, op_ipi_w, eval_en_w;
  logic  take_w, refuse_w, ipi_take_w, ipi_disp_w, allow_disp_w;
  prio_t mfrr_next_w, cppr_eval_w;

  always_comb begin
    busy_w       = (xsrc_q != '0);
    sw_busy_w    = ack_rd || eoi_wr || ipi_wr;
    op_ack_w     = ack_rd;
    op_eoi_w     = eoi_wr && !ack_rd;
    op_ipi_w     = ipi_wr && !ack_rd && !eoi_wr;
    eval_en_w    = op_eoi_w || op_ipi_w;
    mfrr_next_w  = op_ipi_w ? ipi_prio : mfrr_q;
    cppr_eval_w  = op_eoi_w ? eoi_prio : cppr_q;
    allow_disp_w = !(dlv_valid && (dlv_src != '0));
  end

  ipc_accept_arb u_arb (
    .dlv_valid (dlv_valid),
    .dlv_src   (dlv_src),
    .dlv_prio  (dlv_prio),
    .sw_busy   (sw_busy_w),
    .cppr      (cppr_q),
    .busy      (busy_w),
    .pend_prio (pprio_q),
    .take      (take_w),
    .refuse    (refuse_w)
  );

  ipc_ipi_eval #(.IPI_SRC(IPI_SRC)) u_ipi (
    .en             (eval_en_w),
    .mfrr           (mfrr_next_w),
    .cppr           (cppr_eval_w),
    .busy           (busy_w),
    .pend_src       (xsrc_q),
    .pend_prio      (pprio_q),
    .allow_displace (allow_disp_w),
    .present        (ipi_take_w),
    .displace       (ipi_disp_w)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cppr_q    <= '0;
      pprio_q   <= PRIO_NONE;
      mfrr_q    <= PRIO_NONE;
      xsrc_q    <= '0;
      irq_out   <= 1'b0;
      rej_valid <= 1'b0;
      rej_src   <= '0;
    end else begin
      rej_valid <= 1'b0;
      if (op_ack_w) begin
        if (busy_w) begin
          cppr_q  <= pprio_q;
          xsrc_q  <= '0;
          pprio_q <= PRIO_NONE;
          irq_out <= 1'b0;
        end
      end else if (eval_en_w) begin
        cppr_q <= cppr_eval_w;
        mfrr_q <= mfrr_next_w;
        if (ipi_take_w) begin
          if (ipi_disp_w) begin
            rej_valid <= 1'b1;
            rej_src   <= xsrc_q;
          end
          xsrc_q  <= IpiSrc;
          pprio_q <= mfrr_next_w;
          irq_out <= 1'b1;
        end
      end else if (take_w) begin
        if (busy_w && (xsrc_q != IpiSrc)) begin
          rej_valid <= 1'b1;
          rej_src   <= xsrc_q;
        end
        xsrc_q  <= dlv_src;
        pprio_q <= dlv_prio;
        irq_out <= 1'b1;
      end
      // a refusal never coincides with a displacement (see allow_disp_w)
      if (refuse_w) begin
        rej_valid <= 1'b1;
        rej_src   <= dlv_src;
      end
    end
  end

  assign pend_word = {cppr_q, xsrc_q};
endmodule

// File: rtl/ipc_presenter_chk.sv
module ipc_presenter_chk
  import ipc_pkg::*;
#(
  parameter int unsigned IPI_SRC = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              dlv_valid,
  input logic [SRC_W-1:0]  dlv_src,
  input logic [PRIO_W-1:0] dlv_prio,
  input logic              ack_rd,
  input logic              eoi_wr,
  input logic              ipi_wr,
  input logic [WORD_W-1:0] pend_word,
  input logic              irq_out,
  input logic              rej_valid,
  input logic [SRC_W-1:0]  rej_src,
  input logic              take_w,
  input logic              refuse_w,
  input logic              ipi_take_w,
  input prio_t             pprio_q
);
  localparam src_t IpiSrc = src_t'(IPI_SRC);

  p_mask_r2: assert property (@(posedge clk) disable iff (!rst_n)
    take_w |-> (dlv_prio < pend_word[WORD_W-1:SRC_W]));

  p_refuse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    refuse_w |=> (rej_valid && rej_src == $past(dlv_src)));

  p_pending_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (take_w && pend_word[SRC_W-1:0] != '0) |-> (dlv_prio < pprio_q));

  p_accept_r4: assert property (@(posedge clk) disable iff (!rst_n)
    take_w |=> (irq_out && pend_word[SRC_W-1:0] == $past(dlv_src)
                && pend_word[WORD_W-1:SRC_W] == $past(pend_word[WORD_W-1:SRC_W])));

  p_irq_tracks_r4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> (pend_word[SRC_W-1:0] != '0));

  p_ack_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ack_rd |=> (!irq_out && pend_word[SRC_W-1:0] == '0));

  p_ipi_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ipi_take_w |=> (irq_out && pend_word[SRC_W-1:0] == IpiSrc));

  p_collide_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (dlv_valid && dlv_src != '0 && (ack_rd || eoi_wr || ipi_wr))
      |=> (rej_valid && rej_src == $past(dlv_src)));

  p_rej_nonzero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rej_valid |-> (rej_src != '0));
endmodule

bind ipc_presenter ipc_presenter_chk #(.IPI_SRC(IPI_SRC)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .dlv_valid  (dlv_valid),
  .dlv_src    (dlv_src),
  .dlv_prio   (dlv_prio),
  .ack_rd     (ack_rd),
  .eoi_wr     (eoi_wr),
  .ipi_wr     (ipi_wr),
  .pend_word  (pend_word),
  .irq_out    (irq_out),
  .rej_valid  (rej_valid),
  .rej_src    (rej_src),
  .take_w     (take_w),
  .refuse_w   (refuse_w),
  .ipi_take_w (ipi_take_w),
  .pprio_q    (pprio_q)
);

// File: tb/ipc_presenter_bench.sv
`timescale 1ns/1ps
module ipc_presenter_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        dlv_valid = 1'b0;
  logic [23:0] dlv_src = '0;
  logic [7:0]  dlv_prio = '0;
  logic        ack_rd = 1'b0, eoi_wr = 1'b0, ipi_wr = 1'b0;
  logic [7:0]  eoi_prio = '0, ipi_prio = '0;
  logic [31:0] pend_word;
  logic        irq_out, rej_valid;
  logic [23:0] rej_src;

  int tests = 0;
  int fails = 0;
  int cycles = 0;
  bit done = 0;

  // reference state
  int m_cppr, m_src, m_pp, m_mfrr;
  bit e_rej;
  int e_rsrc;

  always #2.5 clk = ~clk;

  ipc_presenter u_ipc_presenter (
    .clk(clk), .rst_n(rst_n), .dlv_valid(dlv_valid), .dlv_src(dlv_src),
    .dlv_prio(dlv_prio), .ack_rd(ack_rd), .eoi_wr(eoi_wr), .eoi_prio(eoi_prio),
    .ipi_wr(ipi_wr), .ipi_prio(ipi_prio), .pend_word(pend_word),
    .irq_out(irq_out), .rej_valid(rej_valid), .rej_src(rej_src)
  );

  function automatic bit beats(int p, int mask, int cur_src, int cur_p);
    if (p >= mask) return 0;
    if (cur_src != 0 && p >= cur_p) return 0;
    return 1;
  endfunction

  task automatic check(string tag);
    bit bad;
    tests++;
    bad = (pend_word != {m_cppr[7:0], m_src[23:0]}) || (irq_out != (m_src != 0))
          || (rej_valid != e_rej) || (e_rej && rej_src != e_rsrc[23:0]);
    if (bad) begin
      fails++;
      $display("FAIL %s: word=%h irq=%0b rej=%0b/%0d expected word=%h irq=%0b rej=%0b/%0d",
               tag, pend_word, irq_out, rej_valid, rej_src,
               {m_cppr[7:0], m_src[23:0]}, m_src != 0, e_rej, e_rsrc);
    end
  endtask

  task automatic step(bit a, bit e, int ev, bit i, int iv, bit d, int ds, int dp);
    bit sw, inc;
    string tag;
    sw = a | e | i;
    inc = d && ds != 0;
    e_rej = 0; e_rsrc = 0;
    tag = "R9";
    if (a) begin
      tag = "R6";
      if (m_src != 0) begin m_cppr = m_pp; m_src = 0; m_pp = 255; end
    end else if (e || i) begin
      if (e) begin m_cppr = ev; tag = "R8"; end
      else begin m_mfrr = iv; tag = "R7"; end
      if (beats(m_mfrr, m_cppr, m_src, m_pp) && (m_src == 0 || m_src == 2 || !inc)) begin
        if (m_src != 0 && m_src != 2) begin e_rej = 1; e_rsrc = m_src; end
        m_src = 2; m_pp = m_mfrr;
      end
    end else if (inc) begin
      if (dp >= m_cppr) begin tag = "R2"; e_rej = 1; e_rsrc = ds; end
      else if (m_src != 0 && dp >= m_pp) begin tag = "R3"; e_rej = 1; e_rsrc = ds; end
      else begin
        tag = "R4";
        if (m_src != 0 && m_src != 2) begin tag = "R5"; e_rej = 1; e_rsrc = m_src; end
        m_src = ds; m_pp = dp;
      end
    end
    if (sw && inc) begin tag = "R9"; e_rej = 1; e_rsrc = ds; end
    ack_rd = a; eoi_wr = e; eoi_prio = ev[7:0]; ipi_wr = i; ipi_prio = iv[7:0];
    dlv_valid = d; dlv_src = ds[23:0]; dlv_prio = dp[7:0];
    @(posedge clk);
    @(negedge clk);
    ack_rd = 0; eoi_wr = 0; ipi_wr = 0; dlv_valid = 0;
    check(tag);
  endtask

  task automatic deliver(int s, int p); step(0, 0, 0, 0, 0, 1, s, p); endtask
  task automatic ack();                 step(1, 0, 0, 0, 0, 0, 0, 0); endtask
  task automatic eoi(int v);            step(0, 1, v, 0, 0, 0, 0, 0); endtask
  task automatic ipi(int v);            step(0, 0, 0, 1, v, 0, 0, 0); endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog: cycles=%0d expected below 100000", cycles);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7177));
    m_cppr = 0; m_src = 0; m_pp = 255; m_mfrr = 255;
    e_rej = 0; e_rsrc = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1");                 // reset state
    deliver(5, 0);               // R2: masked by cppr 0
    eoi(255);                    // R1: MFRR 0xFF presents nothing
    deliver(5, 10);              // R4
    deliver(6, 10);              // R3 equal priority
    deliver(6, 12);              // R3 less favoured
    deliver(7, 3);               // R5 displaces 5
    deliver(8, 255);             // R2 at mask edge
    ipi(1);                      // R7 displaces 7
    deliver(9, 1);               // R3 versus IPI
    ack();                       // R6 cppr=1
    ack();                       // R6 nothing pending
    eoi(255);                    // R8 re-presents source 2
    deliver(9, 0);               // R4 replaces IPI silently
    ipi(255);                    // R7 disabled value
    step(0, 1, 200, 0, 0, 1, 11, 0); // R9 collision
    step(1, 1, 50, 1, 0, 0, 0, 0);   // R9 ack wins
    deliver(0, 0);               // R9 source 0 ignored
    for (int n = 0; n < 600; n++) begin
      int r, s, p;
      r = $urandom_range(99);
      s = $urandom_range(12, 1);
      p = ($urandom_range(3) == 0) ? $urandom_range(255) : $urandom_range(40);
      if (r < 50)      deliver(s, p);
      else if (r < 62) ack();
      else if (r < 77) eoi(($urandom_range(1) == 0) ? 255 : $urandom_range(255));
      else if (r < 87) ipi(($urandom_range(2) == 0) ? 255 : $urandom_range(60));
      else step($urandom_range(1), $urandom_range(1), $urandom_range(255),
                $urandom_range(1), $urandom_range(60), 1, s, p);
    end
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule